// File: doc/BRIEF.md
# Multi-Sector Disk Transfer Sequencer

This block runs the data phase of a disk controller command. Once it is started with a function code, a disk address, an 18-bit memory address and a negative word count, it steps through the transfer one sector at a time. For each sector it can wait for the drive's header word to match the disk address. It then streams all 128 sector words to or from the drive. For the first part of the sector, up to the remaining count, it exchanges words with memory through a single-word DMA handshake. At the end of each sector it moves the disk address on by one and writes the new remaining count back into the count register.

The command ends with a one-cycle `done` pulse. It ends when the count runs out or when an error stops it: the drive is not ready, the address is off the current track, or memory does not answer. Error flags stay set until the next start. The disk address, bus address and count registers are visible as outputs at all times. Bits 17:16 of the bus address appear on `ba_out[17:16]` for a status register.

Top module: `sector_xfer_seq`

## Requirements
- R1: `func` selects the command when `start` is sampled high in idle: 0 = read with header match, 1 = read without header match, 2 = write, 3 = write check. A start loads `da_in`, `ba_in` and `wc_in` and clears all four error flags.
- R2: The remaining count is (0x10000 − wc) mod 2^16. After each completed sector, `wc_out` holds the two's complement of the new remaining count.
- R3: A word count of zero ends the command with `done` two clock edges after `start` is sampled. No header, disk or DMA access takes place.
- R4: Every sector reads or writes all 128 drive words. The DMA moves min(remaining, 128) words, each held on `dma_req` with a stable address until `dma_ack` or `dma_tmo`.
- R5: Functions 0, 2 and 3 keep `hdr_req` high and skip headers until a header word equals the disk address. Function 1 asks for no headers.
- R6: For functions 0, 2 and 3, a sector whose address is off the drive's current track sets `err_hnf` and `err_opi` without transfer. Off track means bits 15:6 differ from `cur_trk`, or bits 5:0 are 40 or more.
- R7: A write sends memory words for the burst and zeros for the rest of the 128-word sector.
- R8: A write check compares all 128 drive words against memory words for the burst and against zero for the tail. It sets `err_wck` on any mismatch and carries on.
- R9: The disk address increments by 1 after each sector, for every function. It never wraps into the next track, so running past sector 39 raises the R6 error.
- R10: `dma_tmo` sets `err_nxm` and `err_opi`, ends the command, and leaves `ba_out` at the failing address plus 2. The disk address and count are not updated for that sector.
- R11: The bus address advances by 2 for each DMA word across the full 18 bits, carrying into bits 17:16.
- R12: `drv_ready` low at any sector boundary ends the command with `err_opi` only.
- R13: `busy` is high from the edge after the start until the edge that raises `done`. `done` is high for exactly one cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a command (sampled in idle) |
| func | input | 2 | Function code |
| da_in | input | 16 | Starting disk address {track, sector} |
| ba_in | input | 18 | Starting bus (memory byte) address |
| wc_in | input | 16 | Negative word count, two's complement |
| cur_trk | input | 10 | Track the drive heads are on |
| drv_ready | input | 1 | Drive ready |
| hdr_req | output | 1 | Header wanted |
| hdr_valid | input | 1 | Header word valid this cycle |
| hdr_word | input | 16 | First header word (sector address) |
| dsk_rd_en | output | 1 | Drive read strobe; data due next cycle |
| dsk_rdata | input | 16 | Drive read data |
| dsk_wr_en | output | 1 | Drive write strobe |
| dsk_wdata | output | 16 | Drive write data |
| dma_req | output | 1 | DMA word request |
| dma_we | output | 1 | 1 = write memory, 0 = read memory |
| dma_addr | output | 18 | DMA byte address |
| dma_wdata | output | 16 | Data to memory |
| dma_rdata | input | 16 | Data from memory, valid with ack |
| dma_ack | input | 1 | DMA word done |
| dma_tmo | input | 1 | DMA word timed out |
| busy | output | 1 | Command running |
| done | output | 1 | One-cycle end-of-command pulse |
| da_out | output | 16 | Disk address register |
| ba_out | output | 18 | Bus address register |
| wc_out | output | 16 | Word count register |
| err_opi | output | 1 | Operation incomplete |
| err_hnf | output | 1 | Header not found |
| err_nxm | output | 1 | Non-existent memory |
| err_wck | output | 1 | Write check mismatch |

## Verification
A zero count gives `done` two edges after `start` is sampled. The bench therefore counts negedges from the release of `start` and expects the pulse on the first one; `busy` is sampled on that same negedge. Drive read data is due one cycle after its strobe. DMA and header answers come one negedge after a request is seen, so the models respond on negedges and the design latches the reply on the next rising edge. Every other result (registers, memory image, written sector, error flags) is read only after `done`, plus two more negedges that also prove the pulse was single.

// File: rtl/sxs_pkg.sv
package sxs_pkg;
  typedef enum logic [1:0] {
    FN_READ    = 2'd0,
    FN_READ_NH = 2'd1,
    FN_WRITE   = 2'd2,
    FN_WCHECK  = 2'd3
  } fn_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BOUND, ST_HDR, ST_WORD, ST_DCAP, ST_DMA, ST_NEXT
  } st_e;
endpackage

// File: rtl/sxs_track_chk.sv
module sxs_track_chk #(
  parameter int DA_W         = 16,
  parameter int SEC_BITS     = 6,
  parameter int SECT_PER_TRK = 40
) (
  input  logic [DA_W-1:0]          da,
  input  logic [DA_W-SEC_BITS-1:0] cur_trk,
  output logic                     on_track
);
  assign on_track = (da[DA_W-1:SEC_BITS] == cur_trk) &&
                    (da[SEC_BITS-1:0] < SEC_BITS'(SECT_PER_TRK));
endmodule

// File: rtl/sxs_burst.sv
module sxs_burst #(
  parameter int WC_W       = 16,
  parameter int SECT_WORDS = 128
) (
  input  logic [WC_W-1:0]              rem,
  output logic [$clog2(SECT_WORDS):0]  burst,
  output logic [WC_W-1:0]              rem_after
);
  localparam int IDX_W = $clog2(SECT_WORDS);
  localparam logic [WC_W-1:0] SW = WC_W'(SECT_WORDS);

  always_comb begin
    if (rem > SW) begin
      burst     = (IDX_W+1)'(SECT_WORDS);
      rem_after = rem - SW;
    end else begin
      burst     = rem[IDX_W:0];
      rem_after = '0;
    end
  end
endmodule

// File: rtl/sector_xfer_seq.sv
module sector_xfer_seq #(
  parameter int DA_W         = 16,
  parameter int BA_W         = 18,
  parameter int WC_W         = 16,
  parameter int DW           = 16,
  parameter int SECT_WORDS   = 128,
  parameter int SEC_BITS     = 6,
  parameter int SECT_PER_TRK = 40
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [1:0]               func,
  input  logic [DA_W-1:0]          da_in,
  input  logic [BA_W-1:0]          ba_in,
  input  logic [WC_W-1:0]          wc_in,
  input  logic [DA_W-SEC_BITS-1:0] cur_trk,
  input  logic                     drv_ready,
  output logic                     hdr_req,
  input  logic                     hdr_valid,
  input  logic [DA_W-1:0]          hdr_word,
  output logic                     dsk_rd_en,
  input  logic [DW-1:0]            dsk_rdata,
  output logic                     dsk_wr_en,
  output logic [DW-1:0]            dsk_wdata,
  output logic                     dma_req,
  output logic                     dma_we,
  output logic [BA_W-1:0]          dma_addr,
  output logic [DW-1:0]            dma_wdata,
  input  logic [DW-1:0]            dma_rdata,
  input  logic                     dma_ack,
  input  logic                     dma_tmo,
  output logic                     busy,
  output logic                     done,
  output logic [DA_W-1:0]          da_out,
  output logic [BA_W-1:0]          ba_out,
  output logic [WC_W-1:0]          wc_out,
  output logic                     err_opi,
  output logic                     err_hnf,
  output logic                     err_nxm,
  output logic                     err_wck
);
  import sxs_pkg::*;

  localparam int IDX_W = $clog2(SECT_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECT_WORDS - 1);

  st_e              st;
  fn_e              fn;
  logic [DA_W-1:0]  da_q;
  logic [BA_W-1:0]  ba_q;
  logic [WC_W-1:0]  wc_q;
  logic [WC_W-1:0]  rem;
  logic [IDX_W-1:0] idx;
  logic [DW-1:0]    dword;
  logic             on_track;
  logic [IDX_W:0]   burst;
  logic [WC_W-1:0]  rem_after;
  logic             in_burst;

  sxs_track_chk #(.DA_W(DA_W), .SEC_BITS(SEC_BITS), .SECT_PER_TRK(SECT_PER_TRK)) u_trk (
    .da(da_q), .cur_trk(cur_trk), .on_track(on_track)
  );

  sxs_burst #(.WC_W(WC_W), .SECT_WORDS(SECT_WORDS)) u_burst (
    .rem(rem), .burst(burst), .rem_after(rem_after)
  );

  assign in_burst = ({1'b0, idx} < burst);
  assign dma_addr = ba_q;
  assign ba_out   = ba_q;
  assign da_out   = da_q;
  assign wc_out   = wc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;         fn <= FN_READ;
      da_q <= '0;            ba_q <= '0;          wc_q <= '0;
      rem <= '0;             idx <= '0;           dword <= '0;
      hdr_req <= 1'b0;       dsk_rd_en <= 1'b0;   dsk_wr_en <= 1'b0;
      dsk_wdata <= '0;       dma_req <= 1'b0;     dma_we <= 1'b0;
      dma_wdata <= '0;       busy <= 1'b0;        done <= 1'b0;
      err_opi <= 1'b0;       err_hnf <= 1'b0;
      err_nxm <= 1'b0;       err_wck <= 1'b0;
    end else begin
      done      <= 1'b0;
      dsk_rd_en <= 1'b0;
      dsk_wr_en <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          fn   <= fn_e'(func);
          da_q <= da_in;
          ba_q <= ba_in;
          wc_q <= wc_in;
          rem  <= WC_W'(0) - wc_in;
          err_opi <= 1'b0; err_hnf <= 1'b0; err_nxm <= 1'b0; err_wck <= 1'b0;
          busy <= 1'b1;
          st   <= ST_BOUND;
        end
        ST_BOUND: begin
          idx <= '0;
          if (rem == '0) begin
            done <= 1'b1; busy <= 1'b0; st <= ST_IDLE;
          end else if (!drv_ready) begin
            err_opi <= 1'b1; done <= 1'b1; busy <= 1'b0; st <= ST_IDLE;
          end else if (fn == FN_READ_NH) begin
            st <= ST_WORD;
          end else if (!on_track) begin
            err_hnf <= 1'b1; err_opi <= 1'b1;
            done <= 1'b1; busy <= 1'b0; st <= ST_IDLE;
          end else begin
            hdr_req <= 1'b1; st <= ST_HDR;
          end
        end
        ST_HDR: if (hdr_valid && hdr_word == da_q) begin
          hdr_req <= 1'b0; st <= ST_WORD;
        end
        ST_WORD: begin
          if (fn != FN_WRITE) begin
            dsk_rd_en <= 1'b1; st <= ST_DCAP;
          end else if (in_burst) begin
            dma_req <= 1'b1; dma_we <= 1'b0; st <= ST_DMA;
          end else begin
            dsk_wr_en <= 1'b1; dsk_wdata <= '0; st <= ST_NEXT;
          end
        end
        ST_DCAP: begin
          dword <= dsk_rdata;
          if (in_burst) begin
            dma_req   <= 1'b1;
            dma_we    <= (fn != FN_WCHECK);
            dma_wdata <= dsk_rdata;
            st        <= ST_DMA;
          end else begin
            if (fn == FN_WCHECK && dsk_rdata != '0) err_wck <= 1'b1;
            st <= ST_NEXT;
          end
        end
        ST_DMA: begin
          if (dma_tmo) begin
            dma_req <= 1'b0; ba_q <= ba_q + BA_W'(2);
            err_nxm <= 1'b1; err_opi <= 1'b1;
            done <= 1'b1; busy <= 1'b0; st <= ST_IDLE;
          end else if (dma_ack) begin
            dma_req <= 1'b0; ba_q <= ba_q + BA_W'(2);
            if (fn == FN_WRITE) begin
              dsk_wr_en <= 1'b1; dsk_wdata <= dma_rdata;
            end
            if (fn == FN_WCHECK && dma_rdata != dword) err_wck <= 1'b1;
            st <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (idx == LAST_IDX) begin
            da_q <= da_q + DA_W'(1);
            rem  <= rem_after;
            wc_q <= WC_W'(0) - rem_after;
            st   <= ST_BOUND;
          end else begin
            idx <= idx + IDX_W'(1);
            st  <= ST_WORD;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sxs_checker.sv
module sxs_checker #(
  parameter int BA_W = 18
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            done,
  input logic            dma_req,
  input logic            dma_ack,
  input logic            dma_tmo,
  input logic [BA_W-1:0] dma_addr,
  input logic [BA_W-1:0] ba_out,
  input logic            err_opi,
  input logic            err_hnf,
  input logic            err_nxm
);
  // R13
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  dma_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !dma_ack && !dma_tmo) |=> (dma_req && $stable(dma_addr)));

  // R11
  ba_step_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_req && (dma_ack || dma_tmo)) |=> (ba_out == $past(ba_out) + BA_W'(2)));

  // R10
  nxm_opi_chk: assert property (@(posedge clk) disable iff (rst)
    err_nxm |-> err_opi);

  // R6
  hnf_opi_chk: assert property (@(posedge clk) disable iff (rst)
    err_hnf |-> err_opi);
endmodule

bind sector_xfer_seq sxs_checker #(.BA_W(BA_W)) u_sxs_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .dma_req(dma_req), .dma_ack(dma_ack), .dma_tmo(dma_tmo),
  .dma_addr(dma_addr), .ba_out(ba_out),
  .err_opi(err_opi), .err_hnf(err_hnf), .err_nxm(err_nxm)
);

// File: tb/sector_xfer_seq_test.sv
module sector_xfer_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  func = 2'd0;
  logic [15:0] da_in = '0;
  logic [17:0] ba_in = '0;
  logic [15:0] wc_in = '0;
  logic [9:0]  cur_trk = 10'h005;
  logic        drv_ready = 1'b1;
  logic        hdr_req, hdr_valid;
  logic [15:0] hdr_word;
  logic        dsk_rd_en, dsk_wr_en;
  logic [15:0] dsk_rdata, dsk_wdata;
  logic        dma_req, dma_we, dma_ack, dma_tmo;
  logic [17:0] dma_addr;
  logic [15:0] dma_wdata, dma_rdata;
  logic        busy, done;
  logic [15:0] da_out, wc_out;
  logic [17:0] ba_out;
  logic        err_opi, err_hnf, err_nxm, err_wck;

  always #10 clk = ~clk;

  sector_xfer_seq uut (
    .clk(clk), .rst(rst), .start(start), .func(func), .da_in(da_in), .ba_in(ba_in),
    .wc_in(wc_in), .cur_trk(cur_trk), .drv_ready(drv_ready), .hdr_req(hdr_req),
    .hdr_valid(hdr_valid), .hdr_word(hdr_word), .dsk_rd_en(dsk_rd_en),
    .dsk_rdata(dsk_rdata), .dsk_wr_en(dsk_wr_en), .dsk_wdata(dsk_wdata),
    .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
    .dma_rdata(dma_rdata), .dma_ack(dma_ack), .dma_tmo(dma_tmo), .busy(busy),
    .done(done), .da_out(da_out), .ba_out(ba_out), .wc_out(wc_out),
    .err_opi(err_opi), .err_hnf(err_hnf), .err_nxm(err_nxm), .err_wck(err_wck)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [15:0] mem [512];
  logic [15:0] wbuf [128];
  int dma_cnt, rd_cnt, wr_cnt, hdr_cnt, done_cnt, hsec, drop_at;
  logic [6:0]  rd_idx;
  logic [7:0]  sq;
  logic [17:0] tmo_addr = 18'h3FFFF;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive, memory and header models, answering on negedges
  initial begin
    dma_ack = 0; dma_tmo = 0; hdr_valid = 0; hdr_word = '0;
    dsk_rdata = '0; dma_rdata = '0;
    forever begin
      @(negedge clk);
      dma_ack = 0; dma_tmo = 0; hdr_valid = 0;
      if (done) done_cnt++;
      if (dma_req) begin
        dma_cnt++;
        if (dma_addr >= tmo_addr) dma_tmo = 1;
        else begin
          dma_ack = 1;
          if (dma_we) mem[dma_addr[9:1]] = dma_wdata;
          else dma_rdata = mem[dma_addr[9:1]];
        end
      end
      if (dsk_rd_en) begin
        dsk_rdata = {sq, 1'b0, rd_idx};
        rd_idx = rd_idx + 7'd1;
        if (rd_idx == 7'd0) sq = sq + 8'd1;
        rd_cnt++;
        if (drop_at != 0 && rd_cnt == drop_at) drv_ready = 0;
      end
      if (dsk_wr_en) begin
        if (wr_cnt < 128) wbuf[wr_cnt] = dsk_wdata;
        wr_cnt++;
      end
      if (hdr_req) begin
        hdr_valid = 1;
        hdr_word = {cur_trk, 6'(hsec)};
        hsec = (hsec == 39) ? 0 : hsec + 1;
        hdr_cnt++;
      end
    end
  end

  task automatic run_cmd(input logic [1:0] f, input logic [15:0] d, input logic [17:0] b,
                         input logic [15:0] w, input int hs, input logic [7:0] s0,
                         output int lat);
    bit seen = 0;
    @(negedge clk);
    dma_cnt = 0; rd_cnt = 0; wr_cnt = 0; hdr_cnt = 0; done_cnt = 0;
    rd_idx = '0; sq = s0; hsec = hs;
    func = f; da_in = d; ba_in = b; wc_in = w; start = 1;
    @(negedge clk);
    start = 0;
    chk("R13 busy after start", busy, 1);
    lat = 0;
    while (!seen && lat < 5000) begin
      @(negedge clk);
      lat++;
      if (done) seen = 1;
    end
    if (!seen) chk("R13 command never finished", 0, 1);
    repeat (2) @(negedge clk);
    chk("R13 single done pulse", done_cnt, 1);
    chk("R13 idle after done", busy, 0);
  endtask

  task automatic t_reset;
    chk("R13 reset busy", busy, 0);
    chk("R13 reset done", done, 0);
    chk("R4 reset dma_req", dma_req, 0);
    chk("R6 reset flags", {err_opi, err_hnf, err_nxm, err_wck}, 0);
  endtask

  task automatic t_read_hdr;  // R5 R2 R4 R9 R11
    int lat;
    for (int i = 0; i < 512; i++) mem[i] = 16'hDEAD;
    run_cmd(2'd0, {10'h005, 6'd3}, 18'h00100, 16'hFF7B, 0, 8'h11, lat);
    chk("R5 header words presented", hdr_cnt, 5);
    chk("R4 dma words", dma_cnt, 133);
    chk("R4 drive words read", rd_cnt, 256);
    chk("R4 mem word 0", mem[9'h080], {8'h11, 8'h00});
    chk("R4 mem word 127", mem[9'h0FF], {8'h11, 8'h7F});
    chk("R4 mem word 128", mem[9'h100], {8'h12, 8'h00});
    chk("R4 mem word 132", mem[9'h104], {8'h12, 8'h04});
    chk("R4 mem past burst untouched", mem[9'h105], 16'hDEAD);
    chk("R11 bus address", ba_out, 18'h0020A);
    chk("R9 disk address", da_out, {10'h005, 6'd5});
    chk("R2 count written back", wc_out, 16'h0000);
    chk("R5 no errors", {err_opi, err_hnf, err_nxm, err_wck}, 0);
  endtask

  task automatic t_read_nohdr;  // R5 R9 R1
    int lat;
    run_cmd(2'd1, {10'h003, 6'd60}, 18'h00300, 16'hFFF6, 0, 8'h22, lat);
    chk("R5 no header request", hdr_cnt, 0);
    chk("R9 disk address increments", da_out, {10'h003, 6'd61});
    chk("R1 read no-header data", mem[9'h189], {8'h22, 8'h09});
    chk("R1 no errors", {err_opi, err_hnf}, 0);
  endtask

  task automatic t_write;  // R7
    int lat;
    bit nz = 0;
    mem[9'h020] = 16'hA001; mem[9'h021] = 16'hA002; mem[9'h022] = 16'hA003;
    run_cmd(2'd2, {10'h005, 6'd0}, 18'h00040, 16'hFFFD, 0, 8'h00, lat);
    chk("R7 whole sector written", wr_cnt, 128);
    chk("R7 word 0", wbuf[0], 16'hA001);
    chk("R7 word 2", wbuf[2], 16'hA003);
    for (int i = 3; i < 128; i++) if (wbuf[i] != 16'h0) nz = 1;
    chk("R7 zero tail", nz, 0);
    chk("R4 dma words", dma_cnt, 3);
  endtask

  task automatic t_wcheck;  // R8
    int lat;
    for (int i = 0; i < 128; i++) mem[9'h100 + i] = {8'h33, 1'b0, 7'(i)};
    run_cmd(2'd3, {10'h005, 6'd2}, 18'h00200, 16'hFF80, 0, 8'h33, lat);
    chk("R8 full match no error", err_wck, 0);
    chk("R2 count zero", wc_out, 0);
    run_cmd(2'd3, {10'h005, 6'd2}, 18'h00200, 16'hFFFB, 0, 8'h33, lat);
    chk("R8 tail compared with zero", err_wck, 1);
    chk("R8 not an abort", err_opi, 0);
    mem[9'h100 + 60] = 16'h1234;
    run_cmd(2'd3, {10'h005, 6'd2}, 18'h00200, 16'hFF80, 0, 8'h33, lat);
    chk("R8 word mismatch", err_wck, 1);
    chk("R8 keeps going", dma_cnt, 128);
  endtask

  task automatic t_off_track;  // R6 R1 R3
    int lat;
    run_cmd(2'd0, {10'h006, 6'd1}, 18'h00000, 16'hFFF0, 0, 8'h00, lat);
    chk("R6 wrong track hnf/opi", {err_hnf, err_opi}, 2'b11);
    chk("R6 no dma", dma_cnt, 0);
    run_cmd(2'd2, {10'h005, 6'd45}, 18'h00000, 16'hFFF0, 0, 8'h00, lat);
    chk("R6 sector beyond track", {err_hnf, err_opi}, 2'b11);
    chk("R6 no write", wr_cnt, 0);
    run_cmd(2'd0, {10'h005, 6'd7}, 18'h00000, 16'h0000, 0, 8'h00, lat);
    chk("R3 zero count latency", lat, 1);
    chk("R3 no dma", dma_cnt, 0);
    chk("R3 no header", hdr_cnt, 0);
    chk("R3 no drive access", rd_cnt, 0);
    chk("R1 flags cleared by start", {err_opi, err_hnf, err_nxm, err_wck}, 0);
    chk("R3 disk address kept", da_out, {10'h005, 6'd7});
  endtask

  task automatic t_no_spiral;  // R9 R2
    int lat;
    run_cmd(2'd0, {10'h005, 6'd39}, 18'h00000, 16'hFF38, 39, 8'h00, lat);
    chk("R9 past last sector", {err_hnf, err_opi}, 2'b11);
    chk("R9 disk address sector 40", da_out, {10'h005, 6'd40});
    chk("R2 remaining 72", wc_out, 16'hFFB8);
    chk("R4 one sector moved", dma_cnt, 128);
  endtask

  task automatic t_timeout;  // R10
    int lat;
    tmo_addr = 18'h00088;
    run_cmd(2'd1, {10'h005, 6'd4}, 18'h00080, 16'hFFF6, 0, 8'h00, lat);
    tmo_addr = 18'h3FFFF;
    chk("R10 nxm and opi", {err_nxm, err_opi}, 2'b11);
    chk("R10 address past failing word", ba_out, 18'h0008A);
    chk("R10 count not updated", wc_out, 16'hFFF6);
    chk("R10 disk address not updated", da_out, {10'h005, 6'd4});
    chk("R10 dma attempts", dma_cnt, 5);
  endtask

  task automatic t_carry;  // R11
    int lat;
    run_cmd(2'd1, {10'h005, 6'd4}, 18'h0FFFC, 16'hFFFC, 0, 8'h00, lat);
    chk("R11 carry into high bits", ba_out, 18'h10004);
    chk("R11 high bits", ba_out[17:16], 2'b01);
  endtask

  task automatic t_not_ready;  // R12
    int lat;
    drv_ready = 0;
    run_cmd(2'd0, {10'h005, 6'd4}, 18'h00000, 16'hFFFC, 0, 8'h00, lat);
    drv_ready = 1;
    chk("R12 opi only", {err_opi, err_hnf, err_nxm}, 3'b100);
    chk("R12 no dma", dma_cnt, 0);
    drop_at = 64;
    run_cmd(2'd1, {10'h005, 6'd4}, 18'h00000, 16'hFF38, 0, 8'h00, lat);
    drop_at = 0; drv_ready = 1;
    chk("R12 stop at boundary", err_opi, 1);
    chk("R12 first sector finished", dma_cnt, 128);
    chk("R12 count after one sector", wc_out, 16'hFFB8);
  endtask

  initial begin
    drop_at = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_read_hdr();
    t_read_nohdr();
    t_write();
    t_wcheck();
    t_off_track();
    t_no_spiral();
    t_timeout();
    t_carry();
    t_not_ready();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule